// File: doc/BRIEF.md
# SPI Register Access Slave

This block lets an external microcontroller read and write a bank of sixty-four 8-bit configuration registers over a four-wire serial link. The serial clock, select and data-in pins are brought into the system clock domain through a short synchronizer chain. All frame decoding then runs on the system clock. The serial clock must stay in each phase for at least four system clock cycles; eight is the comfortable figure. The register bank itself lives outside the block. The block drives an address, write data and a one-cycle write strobe toward it, and takes combinational read data back.

A frame opens when the select line falls. The first byte is a command: its two top bits pick the operation and its low six bits give a starting register index. In a write frame every complete byte that follows is stored at the current index. In a read frame the register contents are returned on the data-out pin. In both cases the index steps by one after each byte and rolls over from 63 to 0. The data-out pin is only driven while read data is being shifted, so it can share a wire with data-in. A pull-down request is raised whenever it floats and the configuration input allows it. Raising select at any time aborts the frame and discards any unfinished byte.

The controlling state machine has five states. ST_IDLE is held while select is high. FRAME_START moves it to ST_CMD once select is seen low. After the eighth command bit, CMD_WRITE leads to ST_WR, CMD_READ leads to ST_RD, and CMD_OTHER leads to ST_SKIP. FRAME_END returns every state to ST_IDLE when select rises.

Top module: `spi_regacc_slave`

## Requirements
- R1: While `spi_ss_n` is high (after synchronization), `spi_miso` is high-impedance, `spi_miso_oe` is 0 and `reg_we` never pulses; reset leaves the block in this state.
- R2: Data-in is sampled on each falling edge of `spi_sclk`, most significant bit first; in the first byte of a frame bits [7:6] are the mode and bits [5:0] the register index.
- R3: Mode 00 (write): each complete byte after the command produces exactly one single-cycle `reg_we` pulse, with `reg_wdata` equal to that byte and `reg_addr` equal to the current index.
- R4: Mode 01 (read): the register at the current index is shifted out on `spi_miso`, MSB first. Each bit is launched after a rising edge of `spi_sclk` and is stable for the master's capture at the next falling edge.
- R5: In both write and read frames, the index increases by one after each complete data byte (burst access).
- R6: The index wraps from 63 to 0 within a burst.
- R7: A data byte that is incomplete when `spi_ss_n` rises is discarded: no write occurs, and the next frame starts counting bits afresh.
- R8: `spi_miso` is high-impedance, and `spi_miso_oe` is 0, during the command byte, during write frames, and at all times outside read-data phases.
- R9: `spi_miso_pd` is 1 exactly when `miso_pd_cfg` is 1 and `spi_miso` is not driven.
- R10: Modes 10 and 11 are ignored: the rest of the frame causes no write and no drive of `spi_miso`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from the master, idle low |
| spi_ss_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial read data, high-impedance when not driven |
| spi_miso_oe | output | 1 | High while `spi_miso` is driven |
| miso_pd_cfg | input | 1 | Allows the pull-down request on the floating data-out pin |
| spi_miso_pd | output | 1 | Pull-down request for the data-out pin |
| reg_addr | output | 6 | Register bank index |
| reg_wdata | output | 8 | Register bank write data |
| reg_we | output | 1 | Single-cycle register write strobe |
| reg_rdata | input | 8 | Register bank read data for `reg_addr` |

## Verification
Writes are exercised with a single byte whose value and index are both asymmetric. A bit-order or field-split error would therefore land on a different register or store a mirrored value. Bursts of three bytes starting at index 62 and 63, in both directions, separate a missing increment from a missing wrap. A frame cut off after four data bits, followed by a normal write, shows both that the partial byte is dropped and that the bit counter restarts. Frames with modes 10 and 11 confirm that nothing is written and that the data-out pin stays floating, with the pull-down request following the configuration input.

// File: rtl/spi_regacc_pkg.sv
package spi_regacc_pkg;

    // Mode codes carried in the two top bits of the command byte
    localparam logic [1:0] MODE_WRITE = 2'b00;
    localparam logic [1:0] MODE_READ  = 2'b01;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_WR,
        ST_RD,
        ST_SKIP
    } frame_state_e;

endpackage

// File: rtl/spi_regacc_sync.sv
module spi_regacc_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] pipe_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe_q <= {STAGES{RST_VAL[b]}};
            end else begin
                pipe_q <= {pipe_q[STAGES-2:0], din[b]};
            end
        end

        assign dout[b] = pipe_q[STAGES-1];
    end

endmodule

// File: rtl/spi_regacc_frame.sv
module spi_regacc_frame
    import spi_regacc_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              ss_s,
    input  logic              mosi_s,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              load_req,
    output logic              launch_req,
    output logic              rd_phase
);

    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    // command byte must be exactly mode bits plus index bits
    initial begin
        if (ADDR_W + 2 != DATA_W) $error("command byte layout mismatch");
    end

    frame_state_e state_q, state_d;

    logic              sclk_d_q;
    logic              sclk_fall, sclk_rise;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic [DATA_W-2:0] rx_sh_q;
    logic [DATA_W-1:0] rx_byte;
    logic              byte_done;
    logic [1:0]        cmd_mode;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              we_q;
    logic              load_q;

    assign sclk_fall = sclk_d_q & ~sclk_s;
    assign sclk_rise = ~sclk_d_q & sclk_s;
    assign rx_byte   = {rx_sh_q, mosi_s};
    assign byte_done = sclk_fall && !ss_s && (bit_cnt_q == LAST_BIT);
    assign cmd_mode  = rx_byte[DATA_W-1 -: 2];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (ss_s) begin
            state_d = ST_IDLE;                       // FRAME_END
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_CMD;           // FRAME_START
                ST_CMD: begin
                    if (byte_done) begin
                        if (cmd_mode == MODE_WRITE)     state_d = ST_WR;   // CMD_WRITE
                        else if (cmd_mode == MODE_READ) state_d = ST_RD;   // CMD_READ
                        else                            state_d = ST_SKIP; // CMD_OTHER
                    end
                end
                ST_WR:   state_d = ST_WR;
                ST_RD:   state_d = ST_RD;
                ST_SKIP: state_d = ST_SKIP;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // edge history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d_q <= 1'b0;
        end else begin
            sclk_d_q <= sclk_s;
        end
    end

    // receive shifter, bit counter, index and strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            rx_sh_q   <= '0;
            addr_q    <= '0;
            wdata_q   <= '0;
            we_q      <= 1'b0;
            load_q    <= 1'b0;
        end else begin
            we_q   <= 1'b0;
            load_q <= 1'b0;
            if (we_q) begin
                addr_q <= addr_q + 1'b1;             // step after the write lands
            end
            if (ss_s) begin
                bit_cnt_q <= '0;
                rx_sh_q   <= '0;
            end else if (sclk_fall) begin
                rx_sh_q   <= rx_byte[DATA_W-2:0];
                bit_cnt_q <= (bit_cnt_q == LAST_BIT) ? '0 : bit_cnt_q + 1'b1;
                if (byte_done) begin
                    unique case (state_q)
                        ST_IDLE, ST_CMD: begin
                            addr_q <= rx_byte[ADDR_W-1:0];
                            load_q <= (cmd_mode == MODE_READ);
                        end
                        ST_WR: begin
                            wdata_q <= rx_byte;
                            we_q    <= 1'b1;
                        end
                        ST_RD: begin
                            addr_q <= addr_q + 1'b1;
                            load_q <= 1'b1;
                        end
                        ST_SKIP: begin
                        end
                        default: begin
                        end
                    endcase
                end
            end
        end
    end

    // outputs
    always_comb begin
        reg_addr   = addr_q;
        reg_wdata  = wdata_q;
        reg_we     = we_q;
        load_req   = load_q;
        rd_phase   = (state_q == ST_RD);
        launch_req = sclk_rise && (state_q == ST_RD) && !ss_s;
    end

    assert_we_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        we_q |=> !we_q);

    assert_we_from_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        we_q |-> ($past(state_q) == ST_WR));

    assert_burst_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        we_q |=> (addr_q == ADDR_W'($past(addr_q) + 1'b1)));

    assert_no_write_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_s && $past(ss_s)) |-> !we_q);

endmodule

// File: rtl/spi_regacc_tx.sv
module spi_regacc_tx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ss_s,
    input  logic              load_req,
    input  logic              launch_req,
    input  logic              rd_phase,
    input  logic [DATA_W-1:0] rdata,
    output logic              miso_bit,
    output logic              miso_oe
);

    logic [DATA_W-1:0] tx_sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh_q  <= '0;
            miso_bit <= 1'b0;
            miso_oe  <= 1'b0;
        end else if (ss_s) begin
            tx_sh_q  <= '0;
            miso_bit <= 1'b0;
            miso_oe  <= 1'b0;
        end else if (load_req) begin
            tx_sh_q <= rdata;
        end else if (launch_req) begin
            miso_bit <= tx_sh_q[DATA_W-1];
            tx_sh_q  <= {tx_sh_q[DATA_W-2:0], 1'b0};
            miso_oe  <= 1'b1;
        end
    end

    assert_oe_read_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        miso_oe |-> rd_phase);

    assert_oe_off_deselect_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ss_s |=> !miso_oe);

endmodule

// File: rtl/spi_regacc_slave.sv
module spi_regacc_slave #(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_ss_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    input  logic              miso_pd_cfg,
    output logic              spi_miso_pd,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    input  logic [DATA_W-1:0] reg_rdata
);

    localparam int N_SYNC = 3;

    logic [N_SYNC-1:0] pins_s;
    logic ss_s, sclk_s, mosi_s;
    logic load_req, launch_req, rd_phase;
    logic miso_bit;

    spi_regacc_sync #(
        .WIDTH   (N_SYNC),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({spi_ss_n, spi_sclk, spi_mosi}),
        .dout  (pins_s)
    );

    assign ss_s   = pins_s[2];
    assign sclk_s = pins_s[1];
    assign mosi_s = pins_s[0];

    spi_regacc_frame #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_s     (sclk_s),
        .ss_s       (ss_s),
        .mosi_s     (mosi_s),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_we     (reg_we),
        .load_req   (load_req),
        .launch_req (launch_req),
        .rd_phase   (rd_phase)
    );

    spi_regacc_tx #(
        .DATA_W (DATA_W)
    ) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .ss_s       (ss_s),
        .load_req   (load_req),
        .launch_req (launch_req),
        .rd_phase   (rd_phase),
        .rdata      (reg_rdata),
        .miso_bit   (miso_bit),
        .miso_oe    (spi_miso_oe)
    );

    assign spi_miso    = spi_miso_oe ? miso_bit : 1'bz;
    assign spi_miso_pd = miso_pd_cfg & ~spi_miso_oe;

    assert_pd_never_when_driving_R9: assert property (@(posedge clk) disable iff (!rst_n)
        spi_miso_oe |-> !spi_miso_pd);

endmodule

// File: tb/spi_regacc_slave_tb.sv
module spi_regacc_slave_tb_top;

    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sclk = 1'b0;
    logic       spi_ss_n = 1'b1;
    logic       spi_mosi = 1'b0;
    logic       miso_pd_cfg = 1'b1;
    wire        spi_miso;
    logic       spi_miso_oe;
    logic       spi_miso_pd;
    logic [5:0] reg_addr;
    logic [7:0] reg_wdata;
    logic       reg_we;
    logic [7:0] reg_rdata;

    logic [7:0] mem [64];
    int         we_count;
    int         n_tests = 0;
    int         n_fail  = 0;
    bit         done    = 1'b0;

    always #5 clk = ~clk;

    spi_regacc_slave dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_sclk    (spi_sclk),
        .spi_ss_n    (spi_ss_n),
        .spi_mosi    (spi_mosi),
        .spi_miso    (spi_miso),
        .spi_miso_oe (spi_miso_oe),
        .miso_pd_cfg (miso_pd_cfg),
        .spi_miso_pd (spi_miso_pd),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_we      (reg_we),
        .reg_rdata   (reg_rdata)
    );

    function automatic logic [7:0] init_val(input int i);
        return 8'((i * 37 + 5) & 8'hFF);
    endfunction

    // external register bank model
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mem[i] <= init_val(i);
            we_count <= 0;
        end else if (reg_we) begin
            mem[reg_addr] <= reg_wdata;
            we_count <= we_count + 1;
        end
    end
    assign reg_rdata = mem[reg_addr];

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame_begin();
        @(negedge clk);
        spi_ss_n = 1'b0;
        waitc(HALF);
    endtask

    task automatic frame_end();
        waitc(HALF);
        spi_ss_n = 1'b1;
        spi_mosi = 1'b0;
        waitc(HALF);
    endtask

    task automatic send_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 7; i > 7 - nbits; i--) begin
            spi_sclk = 1'b1;
            spi_mosi = tx[i];
            waitc(HALF);
            rx[i] = spi_miso;
            spi_sclk = 1'b0;
            waitc(HALF);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        send_bits(tx, 8, rx);
    endtask

    task automatic t_reset();
        chk("R1", "miso idle", {31'b0, spi_miso}, {31'b0, 1'bz});
        chk("R1", "oe idle", {31'b0, spi_miso_oe}, 32'd0);
        chk("R1", "no writes", we_count, 0);
        chk("R9", "pd idle cfg=1", {31'b0, spi_miso_pd}, 32'd1);
        miso_pd_cfg = 1'b0;
        #1;
        chk("R9", "pd idle cfg=0", {31'b0, spi_miso_pd}, 32'd0);
        miso_pd_cfg = 1'b1;
    endtask

    task automatic t_single_write();
        logic [7:0] rx_cmd, rx_dat;
        int base = we_count;
        frame_begin();
        xfer({2'b00, 6'h0A}, rx_cmd);
        xfer(8'h1E, rx_dat);
        frame_end();
        chk("R8", "miso during command", {24'b0, rx_cmd}, {24'b0, 8'hzz});
        chk("R8", "miso during write data", {24'b0, rx_dat}, {24'b0, 8'hzz});
        chk("R2", "write msb-first value/index", {24'b0, mem[10]}, 32'h1E);
        chk("R3", "single write strobe count", we_count - base, 1);
        chk("R2", "mirrored index untouched", {24'b0, mem[20]}, {24'b0, init_val(20)});
    endtask

    task automatic t_burst_write_wrap();
        logic [7:0] rx;
        int base = we_count;
        frame_begin();
        xfer({2'b00, 6'd62}, rx);
        xfer(8'h11, rx);
        xfer(8'h22, rx);
        xfer(8'h33, rx);
        frame_end();
        chk("R5", "burst write index 62", {24'b0, mem[62]}, 32'h11);
        chk("R5", "burst write index 63", {24'b0, mem[63]}, 32'h22);
        chk("R6", "burst write wrap to 0", {24'b0, mem[0]}, 32'h33);
        chk("R3", "burst write strobe count", we_count - base, 3);
    endtask

    task automatic t_single_read();
        logic [7:0] rx;
        frame_begin();
        xfer({2'b01, 6'h0A}, rx);
        chk("R8", "miso during read command", {24'b0, rx}, {24'b0, 8'hzz});
        xfer(8'h00, rx);
        chk("R4", "single read data", {24'b0, rx}, 32'h1E);
        chk("R8", "oe during read phase", {31'b0, spi_miso_oe}, 32'd1);
        chk("R9", "pd off while driving", {31'b0, spi_miso_pd}, 32'd0);
        frame_end();
        chk("R1", "miso released after frame", {31'b0, spi_miso}, {31'b0, 1'bz});
        chk("R9", "pd back after frame", {31'b0, spi_miso_pd}, 32'd1);
    endtask

    task automatic t_burst_read_wrap();
        logic [7:0] rx;
        int base = we_count;
        frame_begin();
        xfer({2'b01, 6'd63}, rx);
        xfer(8'hFF, rx);
        chk("R4", "burst read index 63", {24'b0, rx}, 32'h22);
        xfer(8'hFF, rx);
        chk("R6", "burst read wrap to 0", {24'b0, rx}, 32'h33);
        xfer(8'hFF, rx);
        chk("R5", "burst read index 1", {24'b0, rx}, {24'b0, init_val(1)});
        frame_end();
        chk("R4", "read frame writes nothing", we_count - base, 0);
    endtask

    task automatic t_partial();
        logic [7:0] rx;
        int base = we_count;
        frame_begin();
        xfer({2'b00, 6'd5}, rx);
        send_bits(8'hC3, 4, rx);
        frame_end();
        chk("R7", "partial byte not written", {24'b0, mem[5]}, {24'b0, init_val(5)});
        chk("R7", "partial byte no strobe", we_count - base, 0);
        frame_begin();
        xfer({2'b00, 6'd5}, rx);
        xfer(8'h6B, rx);
        frame_end();
        chk("R7", "next frame realigned", {24'b0, mem[5]}, 32'h6B);
    endtask

    task automatic t_other_modes();
        logic [7:0] rx;
        int base = we_count;
        frame_begin();
        xfer({2'b10, 6'd7}, rx);
        xfer(8'h5A, rx);
        chk("R10", "mode 10 no drive", {24'b0, rx}, {24'b0, 8'hzz});
        chk("R10", "mode 10 pd active", {31'b0, spi_miso_pd}, 32'd1);
        frame_end();
        frame_begin();
        xfer({2'b11, 6'd7}, rx);
        xfer(8'hA5, rx);
        chk("R10", "mode 11 no drive", {24'b0, rx}, {24'b0, 8'hzz});
        frame_end();
        chk("R10", "ignored modes no strobe", we_count - base, 0);
        chk("R10", "ignored modes data kept", {24'b0, mem[7]}, {24'b0, init_val(7)});
    endtask

    initial begin
        waitc(5);
        rst_n = 1'b1;
        waitc(5);
        t_reset();
        t_single_write();
        t_burst_write_wrap();
        t_single_read();
        t_burst_read_wrap();
        t_partial();
        t_other_modes();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule